// File: doc/BRIEF.md
# Single-Register NAND Flash Bridge

This block lets a host processor operate an 8-bit asynchronous NAND flash device through a single 32-bit register. A host write carries an operation code, a chip-enable request and one data byte. The bridge turns each write into one flash bus cycle: a command latch, an address latch or a data write, or it switches the bridge into read mode. The bridge generates the chip-enable, latch-enable and write/read strobes itself.

Once read mode is selected, every host read of the same register pops one byte from the flash. Each such read runs its own read strobe, so no separate data port or FIFO is needed. The word returned to the host also holds a busy flag. This flag combines the synchronized ready/busy pin with the bridge's own activity. Strobe low and high widths come from two configuration inputs that count clock cycles. The host handshake is a request held until a one-cycle ready pulse, so the host is stalled until the strobe sequence ends.

Top module: `nand_reg_bridge`

## Requirements
- R1: For a written operation code 0 to 3, chip enable `nf_ce_n` becomes the inverse of host bit 31. It keeps that value until the next such write.
- R2: Host bits 30:28 select the operation. 0 is a command latch with `nf_cle` high, 1 is an address latch with `nf_ale` high, 2 enters read mode, and 3 is a data write with both latch enables low.
- R3: For codes 0, 1 and 3, host bits 23:16 appear on `nf_dq_o` while `nf_dq_oe` is 1 throughout the write strobe. `nf_dq_oe` is 0 whenever `nf_re_n` is low.
- R4: Each write of code 0, 1 or 3 produces exactly one low pulse on `nf_we_n`.
- R5: In read mode, each host read produces exactly one low pulse on `nf_re_n`. The value of `nf_dq_i` at the strobe's rising edge is returned in bits 23:16 of that read. Read mode persists until a write of code 0, 1 or 3.
- R6: Outside read mode, a host read produces no read strobe and returns the last captured byte.
- R7: Bit 15 of the read word is 1 while `nf_rb_n` is low (sampled through two flops) or while a write or read strobe sequence is in progress. Otherwise it is 0.
- R8: `nf_cle` and `nf_ale` are never high at the same time.
- R9: The strobe low and high phases last `cfg_low` and `cfg_high` clock cycles, where any value below 2 counts as 2. `host_ready` is a single-cycle pulse that ends every access.
- R10: Bits 31:24 and 14:0 of the read word are always 0.
- R11: Writes of codes 4 to 7 complete with no flash strobe. They leave chip enable and read mode unchanged.
- R12: After reset, `nf_ce_n`, `nf_we_n` and `nf_re_n` are 1, `nf_cle`, `nf_ale`, `nf_dq_oe` and `host_ready` are 0, and the bridge is not in read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Access request, held until `host_ready` |
| host_we | input | 1 | 1 for a register write, 0 for a read |
| host_wdata | input | 32 | Written word: enable, operation, byte |
| host_rdata | output | 32 | Read word: byte in 23:16, busy in 15 |
| host_ready | output | 1 | One-cycle pulse ending the access |
| cfg_low | input | CNT_W | Strobe low width in cycles (minimum 2) |
| cfg_high | input | CNT_W | Strobe high width in cycles (minimum 2) |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Flash data bus, outgoing |
| nf_dq_oe | output | 1 | Output enable for the data bus |
| nf_dq_i | input | 8 | Flash data bus, incoming |
| nf_rb_n | input | 1 | Flash ready/busy, low = busy |

## Verification
The bench counts every falling edge of the write and read strobes. This catches a bridge that strobes twice per byte, strobes on an ignored code 4 to 7, or runs a read strobe outside read mode. Each read-mode pop is compared against a flash model whose data changes on every strobe. A bridge that samples on the wrong edge, or returns a stale byte, reports the previous pattern value.

Clamping is checked by measuring the write strobe's low width with a configured width of 0. A design without the clamp would produce a one-cycle or wrapped pulse. The busy flag is checked in three ways: while the pin is low, after it is released, and in the middle of a strobe with the pin ready. A design that reports only the pin would read 0 in that last case.

// File: rtl/nand_reg_bridge.sv
module nand_reg_bridge #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_req,
  input  logic             host_we,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  output logic             host_ready,
  input  logic [CNT_W-1:0] cfg_low,
  input  logic [CNT_W-1:0] cfg_high,
  output logic             nf_ce_n,
  output logic             nf_cle,
  output logic             nf_ale,
  output logic             nf_we_n,
  output logic             nf_re_n,
  output logic [7:0]       nf_dq_o,
  output logic             nf_dq_oe,
  input  logic [7:0]       nf_dq_i,
  input  logic             nf_rb_n
);

  localparam int               MIN_PULSE = 2;
  localparam logic [CNT_W-1:0] MIN_CNT   = CNT_W'(MIN_PULSE);
  localparam logic [2:0]       OP_CMD    = 3'd0;
  localparam logic [2:0]       OP_ADDR   = 3'd1;
  localparam logic [2:0]       OP_RDMODE = 3'd2;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_ACK} state_t;

  state_t           st;
  logic [CNT_W-1:0] cnt;
  logic             rd_mode;
  logic [7:0]       rd_byte;
  logic             rb_meta, rb_sync;

  wire [2:0]       op      = host_wdata[30:28];
  wire [CNT_W-1:0] low_eff = (cfg_low  < MIN_CNT) ? MIN_CNT : cfg_low;
  wire [CNT_W-1:0] hi_eff  = (cfg_high < MIN_CNT) ? MIN_CNT : cfg_high;
  wire             in_seq  = (st == S_LOW) || (st == S_HIGH);
  wire             busy    = !rb_sync || in_seq;

  assign host_ready = (st == S_ACK);
  assign host_rdata = {8'h00, rd_byte, busy, 15'h0000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      rd_mode  <= 1'b0;
      rd_byte  <= 8'h00;
      rb_meta  <= 1'b1;
      rb_sync  <= 1'b1;
      nf_ce_n  <= 1'b1;
      nf_cle   <= 1'b0;
      nf_ale   <= 1'b0;
      nf_we_n  <= 1'b1;
      nf_re_n  <= 1'b1;
      nf_dq_o  <= 8'h00;
      nf_dq_oe <= 1'b0;
    end else begin
      rb_meta <= nf_rb_n;
      rb_sync <= rb_meta;
      case (st)
        S_IDLE: begin
          if (host_req) begin
            if (host_we) begin
              if (!op[2]) begin
                nf_ce_n <= !host_wdata[31];
                if (op == OP_RDMODE) begin
                  rd_mode <= 1'b1;
                  st      <= S_ACK;
                end else begin
                  rd_mode  <= 1'b0;
                  nf_cle   <= (op == OP_CMD);
                  nf_ale   <= (op == OP_ADDR);
                  nf_dq_o  <= host_wdata[23:16];
                  nf_dq_oe <= 1'b1;
                  nf_we_n  <= 1'b0;
                  cnt      <= low_eff - 1'b1;
                  st       <= S_LOW;
                end
              end else begin
                st <= S_ACK;
              end
            end else if (rd_mode) begin
              nf_re_n <= 1'b0;
              cnt     <= low_eff - 1'b1;
              st      <= S_LOW;
            end else begin
              st <= S_ACK;
            end
          end
        end
        S_LOW: begin
          if (cnt == '0) begin
            if (!nf_re_n) rd_byte <= nf_dq_i;
            nf_we_n <= 1'b1;
            nf_re_n <= 1'b1;
            cnt     <= hi_eff - 1'b1;
            st      <= S_HIGH;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_HIGH: begin
          if (cnt == '0) st <= S_ACK;
          else           cnt <= cnt - 1'b1;
        end
        default: begin
          st       <= S_IDLE;
          nf_cle   <= 1'b0;
          nf_ale   <= 1'b0;
          nf_dq_oe <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/nand_reg_bridge_chk.sv
module nand_reg_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] host_rdata,
  input logic        host_ready,
  input logic        nf_ce_n,
  input logic        nf_cle,
  input logic        nf_ale,
  input logic        nf_we_n,
  input logic        nf_re_n,
  input logic [7:0]  nf_dq_o,
  input logic        nf_dq_oe
);

  AST_LATCH_EXCL:   assert property (@(posedge clk) disable iff (!rst_n) !(nf_cle && nf_ale)); // R8
  AST_STROBE_EXCL:  assert property (@(posedge clk) disable iff (!rst_n) !(!nf_we_n && !nf_re_n)); // R4
  AST_NO_DRIVE_RD:  assert property (@(posedge clk) disable iff (!rst_n) !nf_re_n |-> !nf_dq_oe); // R3
  AST_WR_DRIVEN:    assert property (@(posedge clk) disable iff (!rst_n) !nf_we_n |-> nf_dq_oe); // R3
  AST_WR_HOLD:      assert property (@(posedge clk) disable iff (!rst_n)
                      (!nf_we_n && $past(!nf_we_n)) |-> ($stable(nf_dq_o) && $stable(nf_ce_n))); // R1
  AST_WE_MIN_LOW:   assert property (@(posedge clk) disable iff (!rst_n) $rose(nf_we_n) |-> !$past(nf_we_n, 2)); // R9
  AST_RE_MIN_LOW:   assert property (@(posedge clk) disable iff (!rst_n) $rose(nf_re_n) |-> !$past(nf_re_n, 2)); // R9
  AST_READY_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) host_ready |=> !host_ready); // R9
  AST_BUSY_IN_SEQ:  assert property (@(posedge clk) disable iff (!rst_n) (!nf_we_n || !nf_re_n) |-> host_rdata[15]); // R7
  AST_ZERO_FIELDS:  assert property (@(posedge clk) disable iff (!rst_n)
                      (host_rdata[31:24] == 8'h00) && (host_rdata[14:0] == 15'h0000)); // R10

endmodule

bind nand_reg_bridge nand_reg_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_rdata(host_rdata), .host_ready(host_ready),
  .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
  .nf_re_n(nf_re_n), .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe)
);

// File: tb/tb_nand_reg_bridge.sv
module tb_nand_reg_bridge;
  localparam int CNT_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_req = 1'b0, host_we = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic host_ready;
  logic [CNT_W-1:0] cfg_low = 4'd3, cfg_high = 4'd2;
  logic nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
  logic [7:0] nf_dq_o;
  logic [7:0] nf_dq_i = 8'h00;
  logic nf_rb_n = 1'b1;

  always #4 clk = ~clk;

  nand_reg_bridge #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ready(host_ready),
    .cfg_low(cfg_low), .cfg_high(cfg_high), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle),
    .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_o(nf_dq_o),
    .nf_dq_oe(nf_dq_oe), .nf_dq_i(nf_dq_i), .nf_rb_n(nf_rb_n)
  );

  int n_chk = 0, n_err = 0;
  int we_cnt = 0, re_cnt = 0, we_low = 0, last_we_len = 0;
  logic we_prev = 1'b1, re_prev = 1'b1;
  logic cap_cle, cap_ale, cap_oe, cap_busy, cap_re_oe, both_seen = 1'b0;
  logic [7:0] cap_dq;

  function automatic logic [7:0] pat(input int k);
    return 8'h3C ^ 8'(k * 17);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (we_prev && !nf_we_n) begin
        we_cnt++;
        cap_cle = nf_cle; cap_ale = nf_ale; cap_dq = nf_dq_o;
        cap_oe = nf_dq_oe; cap_busy = host_rdata[15];
      end
      if (!nf_we_n) we_low++;
      if (!we_prev && nf_we_n) begin last_we_len = we_low; we_low = 0; end
      if (re_prev && !nf_re_n) begin
        re_cnt++;
        cap_re_oe = nf_dq_oe;
        nf_dq_i = pat(re_cnt);
      end
      if (nf_cle && nf_ale) both_seen = 1'b1;
    end
    we_prev = nf_we_n;
    re_prev = nf_re_n;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  task automatic do_op(input logic we, input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_wdata = wd;
    do @(negedge clk); while (!host_ready);
    rd = host_rdata;
    host_req = 1'b0;
  endtask

  typedef struct packed {
    logic [31:0] wd;
    logic        pulse;
    logic        cle;
    logic        ale;
    logic        ce_n;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{32'h8090_0000, 1'b1, 1'b1, 1'b0, 1'b0},
    '{32'h9012_0000, 1'b1, 1'b0, 1'b1, 1'b0},
    '{32'hB0A5_0000, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h305A_0000, 1'b1, 1'b0, 1'b0, 1'b1},
    '{32'hC077_0000, 1'b0, 1'b0, 1'b0, 1'b1},
    '{32'h0033_0000, 1'b1, 1'b1, 1'b0, 1'b1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int w0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    chk(nf_ce_n && nf_we_n && nf_re_n, "R12", "strobes/ce high", {nf_ce_n, nf_we_n, nf_re_n}, 3'b111);
    chk(!nf_cle && !nf_ale && !nf_dq_oe && !host_ready, "R12", "cle/ale/oe/ready low",
        {nf_cle, nf_ale, nf_dq_oe, host_ready}, 4'b0000);
    r0 = re_cnt;
    do_op(1'b0, 32'h0, rd);
    chk(re_cnt == r0, "R12", "no read mode after reset", re_cnt - r0, 0);
    chk(rd[15] == 1'b0, "R7", "idle ready flag", rd[15], 0);

    for (int i = 0; i < 6; i++) begin
      w0 = we_cnt;
      do_op(1'b1, VEC[i].wd, rd);
      @(negedge clk);
      if (VEC[i].pulse) begin
        chk(we_cnt - w0 == 1, "R4", "one WE strobe", we_cnt - w0, 1);
        chk(cap_cle == VEC[i].cle && cap_ale == VEC[i].ale, "R2", "latch enables",
            {cap_cle, cap_ale}, {VEC[i].cle, VEC[i].ale});
        chk(cap_dq == VEC[i].wd[23:16] && cap_oe, "R3", "data driven", {cap_oe, cap_dq},
            {1'b1, VEC[i].wd[23:16]});
        chk(cap_busy, "R7", "busy mid-sequence", cap_busy, 1);
        chk(last_we_len == 3, "R9", "WE low width", last_we_len, 3);
      end else begin
        chk(we_cnt == w0, "R11", "ignored op no strobe", we_cnt - w0, 0);
      end
      chk(nf_ce_n == VEC[i].ce_n, "R1", "chip enable", nf_ce_n, VEC[i].ce_n);
    end
    chk(!both_seen, "R8", "cle and ale exclusive", both_seen, 0);

    // R5: read mode pops
    do_op(1'b1, 32'hA000_0000, rd);
    chk(nf_ce_n == 1'b0, "R1", "ce on read mode", nf_ce_n, 0);
    for (int k = 1; k <= 3; k++) begin
      r0 = re_cnt;
      do_op(1'b0, 32'h0, rd);
      chk(re_cnt - r0 == 1, "R5", "one RE strobe per read", re_cnt - r0, 1);
      chk(rd[23:16] == pat(re_cnt), "R5", "popped byte", rd[23:16], pat(re_cnt));
      chk(rd[31:24] == 0 && rd[14:0] == 0, "R10", "zero fields", rd, {8'h0, rd[23:16], rd[15], 15'h0});
      chk(!cap_re_oe, "R3", "oe off during RE", cap_re_oe, 0);
    end
    // R11: ignored op keeps read mode and CE
    do_op(1'b1, 32'h6000_0000, rd);
    @(negedge clk);
    chk(nf_ce_n == 1'b0, "R11", "ce kept on ignored op", nf_ce_n, 0);
    r0 = re_cnt;
    do_op(1'b0, 32'h0, rd);
    chk(re_cnt - r0 == 1 && rd[23:16] == pat(re_cnt), "R11", "still read mode", rd[23:16], pat(re_cnt));
    // R6: leave read mode
    do_op(1'b1, 32'h80FF_0000, rd);
    r0 = re_cnt;
    do_op(1'b0, 32'h0, rd);
    chk(re_cnt == r0, "R6", "no RE outside read mode", re_cnt - r0, 0);
    chk(rd[23:16] == pat(re_cnt), "R6", "last byte held", rd[23:16], pat(re_cnt));

    // R7: busy pin through synchronizer
    nf_rb_n = 1'b0;
    repeat (3) @(negedge clk);
    do_op(1'b0, 32'h0, rd);
    chk(rd[15] == 1'b1, "R7", "busy while pin low", rd[15], 1);
    nf_rb_n = 1'b1;
    repeat (3) @(negedge clk);
    do_op(1'b0, 32'h0, rd);
    chk(rd[15] == 1'b0, "R7", "ready after release", rd[15], 0);

    // R9: clamp of low width
    cfg_low = 4'd0;
    do_op(1'b1, 32'h3011_0000, rd);
    @(negedge clk);
    chk(last_we_len == 2, "R9", "clamped WE low width", last_we_len, 2);

    summary();
    $finish;
  end
endmodule